// File: doc/BRIEF.md
# Plane-Predicted Depth Tile Codec

This block packs one square tile of 24-bit depth samples into a short record without losing information, and unpacks such a record back into the tile. On eviction the encoder reads the tile out of a synchronous tile buffer. It takes the sample at the tile's origin as a full-precision anchor. It derives one slope along x and one along y from the two samples next to the anchor, and predicts every sample from the plane these values define. Each sample then keeps a small signed correction against that prediction. The same pass also records the smallest and largest depth in the tile.

If both slopes and every correction fit their fields, the encoder flags the tile as compressed and presents the packed record. If any of them does not fit, it flags the tile as raw. In that case the record carries no meaning and the tile moves along the uncompressed path. The decoder first looks at that flag. For a compressed tile it rebuilds all samples in raster order on a write port. For a raw tile it finishes at once and writes nothing.

Top module: `depth_tile_codec`

## Requirements
- R1: After reset the following outputs are low or zero: enc_done, enc_raw, enc_zmin, enc_zmax, dec_wr_en and dec_done.
- R2: For a compressed tile, record bits [23:0] hold the depth at (0,0). Bits [38:24] hold DX = z(1,0) − z(0,0) and bits [53:39] hold DY = z(0,1) − z(0,0), each in 15-bit two's complement.
- R3: For a compressed tile, the 5-bit two's-complement field at record bit 54+5k holds z(x,y) − (anchor + x·DX + y·DY). Here k = x + 8·y is the sample's index in raster order.
- R4: enc_raw is 1 when any sample's correction falls outside −16..15.
- R5: enc_raw is 1 when DX or DY falls outside −16384..16383.
- R6: enc_zmin and enc_zmax equal the smallest and largest of the 64 depths, for both compressed and raw tiles.
- R7: For a compressed record the decoder emits exactly 64 writes at addresses 0 to 63 in order. Every value written equals the original depth at that address.
- R8: With dec_raw set, the decoder raises dec_done on the first edge after dec_start and issues no write.
- R9: enc_done is a one-cycle pulse. The flag, the depth range and the record are valid from that pulse and are held until the next encode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_start | input | 1 | Begin encoding the tile held in the tile buffer |
| enc_rd_addr | output | 6 | Tile buffer read address (raster index) |
| enc_rd_data | input | 24 | Tile buffer read data, one cycle after the address |
| enc_done | output | 1 | Encode finished (one-cycle pulse) |
| enc_raw | output | 1 | 1: tile must be stored raw; 0: record is valid |
| enc_zmin | output | 24 | Smallest depth in the tile |
| enc_zmax | output | 24 | Largest depth in the tile |
| enc_record | output | 374 | Packed compressed record |
| dec_start | input | 1 | Begin decoding |
| dec_raw | input | 1 | Scheme flag of the tile being loaded |
| dec_record | input | 374 | Packed record to decode |
| dec_wr_en | output | 1 | Rebuilt sample valid |
| dec_wr_addr | output | 6 | Raster index of the rebuilt sample |
| dec_wr_data | output | 24 | Rebuilt depth |
| dec_done | output | 1 | Decode finished (one-cycle pulse) |

## Verification
The bench builds the block with its defaults: an 8×8 tile, 24-bit depth, 15-bit slopes and 5-bit corrections. At these widths the table rows can sit exactly on the limits. One row uses slopes of +16383 and −16384 together with corrections spanning −16..15. Its neighbouring rows go one step over, with a slope of +16384 or a correction of −17, so both the compressed and raw decisions are reached at their edges. Each compressed record is fed straight back into the decoder, which closes the lossless round trip on every such tile.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    DEC_IDLE = 2'd0,
    DEC_RUN  = 2'd1
  } dec_state_e;

  function automatic int rec_width(int dw, int sw, int ow, int side_log);
    return dw + 2 * sw + (1 << (2 * side_log)) * ow;
  endfunction
endpackage

// File: rtl/dtc_encoder.sv
module dtc_encoder #(
  parameter int DW       = 24,
  parameter int SIDE_LOG = 3,
  parameter int SW       = 15,
  parameter int OW       = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic [2*SIDE_LOG-1:0]   rd_addr,
  input  logic [DW-1:0]           rd_data,
  output logic                    done,
  output logic                    raw,
  output logic [DW-1:0]           zmin,
  output logic [DW-1:0]           zmax,
  output logic [dtc_pkg::rec_width(DW, SW, OW, SIDE_LOG)-1:0] record
);
  localparam int AW    = 2 * SIDE_LOG;
  localparam int N     = 1 << AW;
  localparam int RW    = dtc_pkg::rec_width(DW, SW, OW, SIDE_LOG);
  localparam int OBASE = DW + 2 * SW;
  localparam int STEPS = N + 3;
  localparam int CW    = $clog2(STEPS + 1);
  localparam int WW    = DW + 2 * SIDE_LOG + 4;
  localparam logic signed [WW-1:0] SMAX = WW'((1 << (SW - 1)) - 1);
  localparam logic signed [WW-1:0] SMIN = -SMAX - 1;
  localparam logic signed [WW-1:0] OMAX = WW'((1 << (OW - 1)) - 1);
  localparam logic signed [WW-1:0] OMIN = -OMAX - 1;

  logic          busy, vld_d, bad;
  logic [CW-1:0] step, step_d;
  logic [DW-1:0] anc, z10, z01;
  logic [RW-1:0] rec_r;

  logic signed [WW-1:0] anc_s, dx_s, dy_s, xs, ys, pred_s, res_s, smp_s;
  logic [AW-1:0]        kk;
  logic                 slope_bad, res_bad;

  always_comb begin
    if (step == CW'(0))      rd_addr = '0;
    else if (step == CW'(1)) rd_addr = AW'(1);
    else if (step == CW'(2)) rd_addr = AW'(1 << SIDE_LOG);
    else                     rd_addr = AW'(step - CW'(3));
  end

  always_comb begin
    kk        = AW'(step_d - CW'(3));
    anc_s     = $signed(WW'(anc));
    dx_s      = $signed(WW'(z10)) - anc_s;
    dy_s      = $signed(WW'(z01)) - anc_s;
    xs        = $signed(WW'(kk[SIDE_LOG-1:0]));
    ys        = $signed(WW'(kk[AW-1:SIDE_LOG]));
    pred_s    = anc_s + xs * dx_s + ys * dy_s;
    smp_s     = $signed(WW'(rd_data));
    res_s     = smp_s - pred_s;
    slope_bad = (dx_s > SMAX) || (dx_s < SMIN) || (dy_s > SMAX) || (dy_s < SMIN);
    res_bad   = (res_s > OMAX) || (res_s < OMIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; vld_d <= 1'b0; step <= '0; step_d <= '0; bad <= 1'b0;
      anc <= '0; z10 <= '0; z01 <= '0; rec_r <= '0;
      zmin <= '0; zmax <= '0; done <= 1'b0; raw <= 1'b0;
    end else begin
      done   <= 1'b0;
      vld_d  <= busy;
      step_d <= step;
      if (start && !busy) begin
        busy <= 1'b1; step <= '0; bad <= 1'b0;
        zmin <= '1;   zmax <= '0;
      end else if (busy) begin
        if (step == CW'(STEPS - 1)) busy <= 1'b0;
        step <= step + CW'(1);
      end
      if (vld_d) begin
        if (step_d == CW'(0))      anc <= rd_data;
        else if (step_d == CW'(1)) z10 <= rd_data;
        else if (step_d == CW'(2)) z01 <= rd_data;
        else begin
          rec_r[OBASE + int'(kk) * OW +: OW] <= res_s[OW-1:0];
          if (res_bad) bad <= 1'b1;
          if (rd_data < zmin) zmin <= rd_data;
          if (rd_data > zmax) zmax <= rd_data;
          if (step_d == CW'(STEPS - 1)) begin
            done <= 1'b1;
            raw  <= bad | res_bad | slope_bad;
            rec_r[DW-1:0]       <= anc;
            rec_r[DW +: SW]     <= dx_s[SW-1:0];
            rec_r[DW + SW +: SW] <= dy_s[SW-1:0];
          end
        end
      end
    end
  end

  assign record = rec_r;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_range_order_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> zmin <= zmax);
endmodule

// File: rtl/dtc_decoder.sv
module dtc_decoder #(
  parameter int DW       = 24,
  parameter int SIDE_LOG = 3,
  parameter int SW       = 15,
  parameter int OW       = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  raw,
  input  logic [dtc_pkg::rec_width(DW, SW, OW, SIDE_LOG)-1:0] record,
  output logic                  wr_en,
  output logic [2*SIDE_LOG-1:0] wr_addr,
  output logic [DW-1:0]         wr_data,
  output logic                  done
);
  localparam int AW    = 2 * SIDE_LOG;
  localparam int N     = 1 << AW;
  localparam int RW    = dtc_pkg::rec_width(DW, SW, OW, SIDE_LOG);
  localparam int OBASE = DW + 2 * SW;
  localparam int WW    = DW + 2 * SIDE_LOG + 4;

  dtc_pkg::dec_state_e  st;
  logic [AW-1:0]        k;
  logic                 fin;
  logic [RW-1:0]        rec_l;
  logic signed [WW-1:0] anc_s, dx_s, dy_s, off_s, xs, ys, val_s;
  logic signed [OW-1:0] off_f;

  always_comb begin
    anc_s = $signed(WW'(rec_l[DW-1:0]));
    dx_s  = WW'($signed(rec_l[DW +: SW]));
    dy_s  = WW'($signed(rec_l[DW + SW +: SW]));
    off_f = $signed(rec_l[OBASE + int'(k) * OW +: OW]);
    off_s = WW'(off_f);
    xs    = $signed(WW'(k[SIDE_LOG-1:0]));
    ys    = $signed(WW'(k[AW-1:SIDE_LOG]));
    val_s = anc_s + xs * dx_s + ys * dy_s + off_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= dtc_pkg::DEC_IDLE; k <= '0; fin <= 1'b0; rec_l <= '0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; done <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      fin   <= 1'b0;
      done  <= fin;
      if (st == dtc_pkg::DEC_IDLE) begin
        if (start && raw) done <= 1'b1;
        else if (start) begin
          st <= dtc_pkg::DEC_RUN; k <= '0; rec_l <= record;
        end
      end else begin
        wr_en   <= 1'b1;
        wr_addr <= k;
        wr_data <= val_s[DW-1:0];
        k       <= k + AW'(1);
        if (k == AW'(N - 1)) begin
          st  <= dtc_pkg::DEC_IDLE;
          fin <= 1'b1;
        end
      end
    end
  end

  assert_wr_order_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> wr_addr == $past(wr_addr) + AW'(1));
  assert_wr_first_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> wr_addr == '0);
  assert_raw_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (start && raw && st == dtc_pkg::DEC_IDLE) |=> (done && !wr_en));
endmodule

// File: rtl/depth_tile_codec.sv
module depth_tile_codec #(
  parameter int DW       = 24,
  parameter int SIDE_LOG = 3,
  parameter int SW       = 15,
  parameter int OW       = 5,
  localparam int AW      = 2 * SIDE_LOG,
  localparam int RW      = dtc_pkg::rec_width(DW, SW, OW, SIDE_LOG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enc_start,
  output logic [AW-1:0] enc_rd_addr,
  input  logic [DW-1:0] enc_rd_data,
  output logic          enc_done,
  output logic          enc_raw,
  output logic [DW-1:0] enc_zmin,
  output logic [DW-1:0] enc_zmax,
  output logic [RW-1:0] enc_record,
  input  logic          dec_start,
  input  logic          dec_raw,
  input  logic [RW-1:0] dec_record,
  output logic          dec_wr_en,
  output logic [AW-1:0] dec_wr_addr,
  output logic [DW-1:0] dec_wr_data,
  output logic          dec_done
);
  dtc_encoder #(.DW(DW), .SIDE_LOG(SIDE_LOG), .SW(SW), .OW(OW)) u_enc (
    .clk(clk), .rst(rst), .start(enc_start), .rd_addr(enc_rd_addr),
    .rd_data(enc_rd_data), .done(enc_done), .raw(enc_raw),
    .zmin(enc_zmin), .zmax(enc_zmax), .record(enc_record));

  dtc_decoder #(.DW(DW), .SIDE_LOG(SIDE_LOG), .SW(SW), .OW(OW)) u_dec (
    .clk(clk), .rst(rst), .start(dec_start), .raw(dec_raw),
    .record(dec_record), .wr_en(dec_wr_en), .wr_addr(dec_wr_addr),
    .wr_data(dec_wr_data), .done(dec_done));
endmodule

// File: tb/sim_depth_tile_codec.sv
module sim_depth_tile_codec;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24, SL = 3, SW = 15, OW = 5;
  localparam int N = 64, RW = DW + 2 * SW + N * OW;
  localparam int NV = 7;
  localparam int VA[NV] = '{1000, 8388608, 500000, 100, 5000000, 0, 16000000};
  localparam int VX[NV] = '{3, -200, 16383, 16384, -10, 0, 1000};
  localparam int VY[NV] = '{5, 150, -16384, 0, 20, 0, -16385};
  localparam int VM[NV] = '{10, 15, 16, 0, 17, 0, 3};
  localparam int VR[NV] = '{0, 0, 0, 1, 1, 0, 1};

  logic clk = 0, rst = 1;
  logic enc_start = 0, dec_start = 0, dec_raw = 0;
  logic [5:0] enc_rd_addr, dec_wr_addr;
  logic [DW-1:0] enc_rd_data, enc_zmin, enc_zmax, dec_wr_data;
  logic enc_done, enc_raw, dec_wr_en, dec_done;
  logic [RW-1:0] enc_record, dec_record;

  logic [DW-1:0] tile [N];
  logic [DW-1:0] cap [N];
  int cap_cnt, order_bad, n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always_ff @(posedge clk) enc_rd_data <= tile[enc_rd_addr];

  depth_tile_codec u0 (.*);

  always @(negedge clk) if (dec_wr_en) begin
    if (int'(dec_wr_addr) != cap_cnt) order_bad++;
    cap[dec_wr_addr] = dec_wr_data;
    cap_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int r);
    for (int k = 0; k < N; k++) begin
      int x = k % 8, y = k / 8, off;
      off = (VM[r] > 0) ? ((x * 7 + y * 13) % (2 * VM[r])) - VM[r] : 0;
      if (k < 2 || k == 8) off = 0;
      tile[k] = DW'(VA[r] + x * VX[r] + y * VY[r] + off);
    end
  endtask

  task automatic run_row(input int r);
    logic [RW-1:0] exp_rec;
    int a, dx, dy, res, mn, mx, bad, w;
    fill(r);
    a = int'(tile[0]); dx = int'(tile[1]) - a; dy = int'(tile[8]) - a;
    bad = (dx > 16383 || dx < -16384 || dy > 16383 || dy < -16384);
    exp_rec = '0;
    exp_rec[23:0] = DW'(a); exp_rec[38:24] = 15'(dx); exp_rec[53:39] = 15'(dy);
    mn = 32'hFFFFFF; mx = 0;
    for (int k = 0; k < N; k++) begin
      res = int'(tile[k]) - (a + (k % 8) * dx + (k / 8) * dy);
      if (res > 15 || res < -16) bad = 1;
      exp_rec[54 + 5 * k +: 5] = 5'(res);
      if (int'(tile[k]) < mn) mn = int'(tile[k]);
      if (int'(tile[k]) > mx) mx = int'(tile[k]);
    end
    @(negedge clk) enc_start = 1;
    @(negedge clk) enc_start = 0;
    w = 0;
    while (!enc_done && w < 300) begin @(negedge clk); w++; end
    chk(w < 300, "R9 encode done seen", RW'(w), RW'(0));
    chk(enc_raw == 1'(bad) && bad == VR[r], "R4/R5 scheme flag", RW'(enc_raw), RW'(VR[r]));
    chk(int'(enc_zmin) == mn, "R6 zmin", RW'(enc_zmin), RW'(mn));
    chk(int'(enc_zmax) == mx, "R6 zmax", RW'(enc_zmax), RW'(mx));
    if (!bad) begin
      chk(enc_record[53:0] == exp_rec[53:0], "R2 anchor and slopes", enc_record, exp_rec);
      chk(enc_record == exp_rec, "R3 correction fields", enc_record, exp_rec);
    end
    @(negedge clk);
    chk(!enc_done && enc_raw == 1'(bad), "R9 pulse and hold", RW'({enc_done, enc_raw}), RW'(bad));
    cap_cnt = 0; order_bad = 0;
    dec_record = enc_record; dec_raw = 1'(bad);
    dec_start = 1;
    @(negedge clk) dec_start = 0;
    if (bad) begin
      chk(dec_done && cap_cnt == 0, "R8 raw decode", RW'({dec_done, 8'(cap_cnt)}), RW'(9'h100));
      repeat (3) @(negedge clk);
      chk(cap_cnt == 0, "R8 no writes", RW'(cap_cnt), RW'(0));
    end else begin
      int mism = 0;
      w = 0;
      while (!dec_done && w < 300) begin @(negedge clk); w++; end
      for (int k = 0; k < N; k++) if (cap[k] !== tile[k]) mism++;
      chk(cap_cnt == N && order_bad == 0, "R7 write count and order", RW'(cap_cnt), RW'(N));
      chk(mism == 0, "R7 lossless round trip", RW'(mism), RW'(0));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) tile[k] = '0;
    dec_record = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!enc_done && !enc_raw && enc_zmin == 0 && enc_zmax == 0 && !dec_wr_en && !dec_done,
        "R1 reset state", RW'({enc_done, enc_raw, dec_wr_en, dec_done}), RW'(0));
    for (int r = 0; r < NV; r++) run_row(r);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule